// File: doc/BRIEF.md
# Dual-Buffer Frame Transmit Controller

This block is the host side of the transmit path of a small Ethernet MAC. Software reaches it through a 32-bit register bus with a one-cycle read latency. It holds one or two frame buffers at a fixed stride of `BUF_BYTES` bytes. Each buffer has its own data memory, a length register and a control/status word. Software writes the frame into a buffer, writes the length, and then sets the busy bit. The block then streams the frame out one byte at a time on a valid/ready interface. When the last byte has been accepted, it drops busy. If that buffer has its interrupt enabled, it also raises a single-cycle interrupt.

A second command in the same status word, busy together with program, sends nothing. Instead it copies the first six bytes of the buffer into the station address output. The second buffer is present only when `HAS_PONG` is set, so software can fill one buffer while the other drains. Framing, CRC and PHY signalling belong to the stage downstream of the byte stream.

Top module: `tx_pingpong_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every status and length register reads 0, `tx_valid` and `tx_irq` are low and `mac_addr` is 0.
- R2: Within each buffer region, the length register is at byte offset `BUF_BYTES-12` and only its low 16 bits are stored; upper bits read 0. The status word is at offset `BUF_BYTES-4` and its fields are: bit 0 busy, bit 1 program, bit 3 interrupt enable, bit 31 software flag. All other status bits read 0. Buffer 1 repeats the layout at offset `BUF_BYTES`, selected by address bit `log2(BUF_BYTES)`.
- R3: Writing a status word with bit 0 set and bit 1 clear to an idle buffer sends `length` bytes from the start of that buffer. Within each 32-bit word, bits [31:24] go first. `tx_last` is high only on the final byte.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values until the byte is accepted.
- R5: Busy clears once the last byte is accepted. If the buffer's interrupt enable is set, `tx_irq` is high for exactly one cycle at that point; otherwise it stays low.
- R6: Writing bits 0 and 1 together to an idle buffer loads `mac_addr` from the buffer's first six bytes, with byte 0 in `mac_addr[47:40]`. Busy and program then clear. Nothing is streamed and no interrupt is raised.
- R7: The software flag (bit 31) is stored and read back unchanged. It never starts, stops or alters a transfer.
- R8: Only completion or a write of the value 0 clears busy. A nonzero write with bit 0 clear only updates the interrupt enable and software flag. A zero write returns the buffer to idle and aborts its frame: `tx_valid` is low in the next cycle, and no interrupt is raised.
- R9: When both buffers are busy, frames go out in the order they were armed. Each frame is sent completely before the next one starts, and `tx_valid` is low in the cycle after a `tx_last` handshake.
- R10: A length of 0 sends no bytes, clears busy and raises the interrupt if it is enabled.
- R11: A length larger than the data area (`BUF_BYTES-12` bytes, 2036 by default) is treated as exactly that size.
- R12: With `HAS_PONG` = 0, accesses to the second region are ignored: its registers read 0 and arming it sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | Byte on `tx_data` is valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_last | output | 1 | Final byte of the frame |
| mac_addr | output | 48 | Programmed station address |
| tx_irq | output | 1 | Transmit-complete pulse |

## Verification
The bench targets the following cases, and the symptom a faulty design would show in each:
- **Byte order.** A swapped byte order or a wrong lane scrambles the stream.
- **Frame length.** Frames of length 1, 0, non-multiples of four, and lengths above the data area. An off-by-one counter would drop or repeat the tail byte, or put `tx_last` on the wrong byte.
- **Arming order.** Two buffers are armed while the output is stalled. A fixed priority would send them out of arming order.
- **Zero-write abort.** A zero write during a stalled frame must cut the stream at once. A design that only updated fields would keep streaming.
- **Address programming and the software flag.** Programming the address must not leak bytes onto the stream or raise an interrupt. The software flag is checked for readback and for having no effect. A design that decoded the flag as busy would start a transfer.

// File: rtl/tx_pp_pkg.sv
// Package: shared types of the dual-buffer transmit controller.
// Assumes: status word layout busy=bit0, program=bit1, irq enable=bit3,
// software flag=bit31; all other bits read zero.
package tx_pp_pkg;

    // Sequencer states of the drain engine.
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FETCH,
        SQ_LOAD,
        SQ_SEND,
        SQ_PROG0,
        SQ_PROG1,
        SQ_PROG2,
        SQ_DONE
    } seq_state_e;

    // Stored control/status fields of one buffer.
    typedef struct packed {
        logic sw_flag;
        logic irq_en;
        logic prog;
        logic busy;
    } tx_stat_t;

    // Map the stored fields onto the 32-bit status word seen on the bus.
    function automatic logic [31:0] stat_to_word(input tx_stat_t s);
        logic [31:0] w;
        w     = '0;
        w[0]  = s.busy;
        w[1]  = s.prog;
        w[3]  = s.irq_en;
        w[31] = s.sw_flag;
        return w;
    endfunction

endpackage

// File: rtl/tx_buf_bank.sv
// Module: one transmit buffer region: data memory, length and status.
// Does: decodes word offsets inside its region, stores frame words, the
// length and status fields, serves bus reads (one cycle latency, zero when
// not read) and a second read port for the drain engine.
// Assumes: accesses are word aligned; wr_en/rd_en already qualified by the
// region select in the top module.
module tx_buf_bank
    import tx_pp_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter int OFF_W     = 11,
    parameter int LEN_W     = 16,
    parameter int WA_W      = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [OFF_W-1:0] offs,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic [WA_W-1:0]  drain_addr,
    output logic [31:0]      drain_word,
    input  logic             done_i,
    output tx_stat_t         stat_o,
    output logic [LEN_W-1:0] len_o,
    output logic             irq_o
);

    localparam int DATA_BYTES = BUF_BYTES - 12;
    localparam int DATA_WORDS = DATA_BYTES / 4;
    localparam int LEN_WIDX   = (BUF_BYTES - 12) / 4;
    localparam int STAT_WIDX  = (BUF_BYTES - 4) / 4;
    localparam int WI_W       = OFF_W - 2;

    logic [31:0]      mem [DATA_WORDS];
    logic [WI_W-1:0]  widx;
    logic             is_len;
    logic             is_stat;
    logic             is_data;
    tx_stat_t         stat_q;
    logic [LEN_W-1:0] len_q;

    // Word-offset decode inside the region.
    always_comb begin
        widx    = offs[OFF_W-1:2];
        is_len  = (widx == WI_W'(LEN_WIDX));
        is_stat = (widx == WI_W'(STAT_WIDX));
        is_data = (widx < WI_W'(DATA_WORDS));
    end

    // Frame data memory: bus write port and registered drain read port.
    always_ff @(posedge clk) begin
        if (wr_en && is_data) begin
            mem[widx[WA_W-1:0]] <= wdata;
        end
        drain_word <= mem[drain_addr];
    end

    // Length register, low LEN_W bits only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (wr_en && is_len) begin
            len_q <= wdata[LEN_W-1:0];
        end
    end

    // Status fields: completion clears busy/program, bus writes arm or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            if (done_i) begin
                stat_q.busy <= 1'b0;
                stat_q.prog <= 1'b0;
            end
            if (wr_en && is_stat) begin
                if (wdata == 32'd0) begin
                    stat_q <= '0;
                end else begin
                    stat_q.sw_flag <= wdata[31];
                    stat_q.irq_en  <= wdata[3];
                    if (!stat_q.busy && wdata[0]) begin
                        stat_q.busy <= 1'b1;
                        stat_q.prog <= wdata[1];
                    end
                end
            end
        end
    end

    // Completion interrupt: one cycle, only for sends with enable set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= done_i && stat_q.busy && !stat_q.prog && stat_q.irq_en;
        end
    end

    // Bus read data, registered, zero on cycles without a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (!rd_en) begin
            rdata <= '0;
        end else if (is_stat) begin
            rdata <= stat_to_word(stat_q);
        end else if (is_len) begin
            rdata <= 32'(len_q);
        end else if (is_data) begin
            rdata <= mem[widx[WA_W-1:0]];
        end else begin
            rdata <= '0;
        end
    end

    assign stat_o = stat_q;
    assign len_o  = len_q;

endmodule

// File: rtl/tx_drain_seq.sv
// Module: drain engine shared by all buffers.
// Does: picks the next busy buffer after the one served last (arm order for
// two buffers), streams its bytes big-endian with valid/ready, or loads the
// station address for a program command, then pulses done for that buffer.
// Assumes: banks return drain_word one cycle after drain_addr; a buffer whose
// busy drops mid-job has been reset by software and is abandoned at once.
module tx_drain_seq
    import tx_pp_pkg::*;
#(
    parameter int NBUF    = 2,
    parameter int LEN_W   = 16,
    parameter int WA_W    = 9,
    parameter int MAX_LEN = 2036
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NBUF-1:0]            busy_i,
    input  logic [NBUF-1:0]            prog_i,
    input  logic [NBUF-1:0][LEN_W-1:0] len_i,
    input  logic [NBUF-1:0][31:0]      word_i,
    output logic [WA_W-1:0]            rd_addr,
    output logic [NBUF-1:0]            done_o,
    output logic [7:0]                 tx_data,
    output logic                       tx_valid,
    input  logic                       tx_ready,
    output logic                       tx_last,
    output logic [47:0]                mac_addr
);

    localparam int SEL_W = (NBUF > 1) ? $clog2(NBUF) : 1;

    seq_state_e       state_q;
    logic [SEL_W-1:0] sel_q;
    logic [SEL_W-1:0] last_q;
    logic [WA_W-1:0]  word_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] flen_q;
    logic [31:0]      wreg_q;
    logic [47:0]      mac_q;
    logic             pick_ok;
    logic [SEL_W-1:0] pick_idx;
    logic [LEN_W-1:0] pick_len;
    logic             cur_busy;
    logic [LEN_W-1:0] cnt_nxt;
    logic             at_end;

    // Rotating pick: first busy buffer after the one served last.
    always_comb begin
        pick_ok  = 1'b0;
        pick_idx = '0;
        for (int k = NBUF; k >= 1; k--) begin
            int cand;
            cand = (int'(last_q) + k) % NBUF;
            if (busy_i[cand]) begin
                pick_ok  = 1'b1;
                pick_idx = SEL_W'(cand);
            end
        end
    end

    // Length of the picked buffer, clamped to the data area.
    always_comb begin
        pick_len = len_i[pick_idx];
        if (pick_len > LEN_W'(MAX_LEN)) begin
            pick_len = LEN_W'(MAX_LEN);
        end
    end

    // Byte counter look-ahead and current-job busy.
    always_comb begin
        cur_busy = busy_i[sel_q];
        cnt_nxt  = cnt_q + 1'b1;
        at_end   = (cnt_nxt == flen_q);
    end

    // Main sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            sel_q   <= '0;
            last_q  <= SEL_W'(NBUF - 1);
            word_q  <= '0;
            cnt_q   <= '0;
            flen_q  <= '0;
            wreg_q  <= '0;
            mac_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (pick_ok) begin
                        sel_q  <= pick_idx;
                        word_q <= '0;
                        cnt_q  <= '0;
                        flen_q <= pick_len;
                        if (prog_i[pick_idx]) begin
                            state_q <= SQ_PROG0;
                        end else if (pick_len == '0) begin
                            state_q <= SQ_DONE;
                        end else begin
                            state_q <= SQ_FETCH;
                        end
                    end
                end
                SQ_FETCH: state_q <= cur_busy ? SQ_LOAD : SQ_IDLE;
                SQ_LOAD: begin
                    wreg_q  <= word_i[sel_q];
                    state_q <= cur_busy ? SQ_SEND : SQ_IDLE;
                end
                SQ_SEND: begin
                    if (!cur_busy) begin
                        state_q <= SQ_IDLE;
                        last_q  <= sel_q;
                    end else if (tx_ready) begin
                        cnt_q <= cnt_nxt;
                        if (at_end) begin
                            state_q <= SQ_DONE;
                        end else if (cnt_q[1:0] == 2'd3) begin
                            word_q  <= word_q + 1'b1;
                            state_q <= SQ_FETCH;
                        end else begin
                            wreg_q <= {wreg_q[23:0], 8'h00};
                        end
                    end
                end
                SQ_PROG0: state_q <= cur_busy ? SQ_PROG1 : SQ_IDLE;
                SQ_PROG1: begin
                    wreg_q  <= word_i[sel_q];
                    state_q <= cur_busy ? SQ_PROG2 : SQ_IDLE;
                end
                SQ_PROG2: begin
                    if (cur_busy) begin
                        mac_q   <= {wreg_q, word_i[sel_q][31:16]};
                        state_q <= SQ_DONE;
                    end else begin
                        state_q <= SQ_IDLE;
                    end
                end
                SQ_DONE: begin
                    last_q  <= sel_q;
                    state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Drain read address: words 0 and 1 for programming, else frame word.
    always_comb begin
        if (state_q == SQ_PROG0) begin
            rd_addr = '0;
        end else if (state_q == SQ_PROG1) begin
            rd_addr = WA_W'(1);
        end else begin
            rd_addr = word_q;
        end
    end

    // One-hot completion pulse toward the served buffer.
    always_comb begin
        for (int b = 0; b < NBUF; b++) begin
            done_o[b] = (state_q == SQ_DONE) && (sel_q == SEL_W'(b));
        end
    end

    // Stream outputs; a reset buffer drops valid immediately.
    always_comb begin
        tx_valid = (state_q == SQ_SEND) && cur_busy;
        tx_data  = wreg_q[31:24];
        tx_last  = tx_valid && at_end;
        mac_addr = mac_q;
    end

endmodule

// File: rtl/tx_pingpong_ctrl.sv
// Module: top of the dual-buffer frame transmit controller.
// Does: selects a buffer region from the address bit above the region
// offset, instantiates one bank per present buffer, merges read data and
// interrupts, and shares one drain engine across the banks.
// Assumes: BUF_BYTES is a power of two; LEN_W can hold BUF_BYTES-12.
module tx_pingpong_ctrl
    import tx_pp_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter bit HAS_PONG  = 1'b1,
    parameter int LEN_W     = 16,
    parameter int OFF_W     = $clog2(BUF_BYTES),
    parameter int ADDR_W    = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_last,
    output logic [47:0]       mac_addr,
    output logic              tx_irq
);

    localparam int NBUF       = HAS_PONG ? 2 : 1;
    localparam int MAX_LEN    = BUF_BYTES - 12;
    localparam int DATA_WORDS = MAX_LEN / 4;
    localparam int WA_W       = $clog2(DATA_WORDS);

    logic [NBUF-1:0][31:0]      bank_rdata;
    logic [NBUF-1:0][31:0]      bank_word;
    logic [NBUF-1:0]            bank_busy;
    logic [NBUF-1:0]            bank_prog;
    logic [NBUF-1:0][LEN_W-1:0] bank_len;
    logic [NBUF-1:0]            bank_irq;
    logic [NBUF-1:0]            bank_done;
    logic [WA_W-1:0]            drain_addr;

    // One bank per present buffer, selected by the region bit.
    for (genvar g = 0; g < NBUF; g++) begin : g_bank
        logic     hit;
        tx_stat_t st;
        assign hit = (bus_addr[OFF_W] == g[0]);

        tx_buf_bank #(
            .BUF_BYTES(BUF_BYTES),
            .OFF_W    (OFF_W),
            .LEN_W    (LEN_W),
            .WA_W     (WA_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (bus_en && bus_we && hit),
            .rd_en     (bus_en && !bus_we && hit),
            .offs      (bus_addr[OFF_W-1:0]),
            .wdata     (bus_wdata),
            .rdata     (bank_rdata[g]),
            .drain_addr(drain_addr),
            .drain_word(bank_word[g]),
            .done_i    (bank_done[g]),
            .stat_o    (st),
            .len_o     (bank_len[g]),
            .irq_o     (bank_irq[g])
        );

        assign bank_busy[g] = st.busy;
        assign bank_prog[g] = st.prog;
    end

    // Merge read data and interrupts; idle banks contribute zero.
    always_comb begin
        bus_rdata = '0;
        tx_irq    = 1'b0;
        for (int b = 0; b < NBUF; b++) begin
            bus_rdata = bus_rdata | bank_rdata[b];
            tx_irq    = tx_irq | bank_irq[b];
        end
    end

    tx_drain_seq #(
        .NBUF   (NBUF),
        .LEN_W  (LEN_W),
        .WA_W   (WA_W),
        .MAX_LEN(MAX_LEN)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_i  (bank_busy),
        .prog_i  (bank_prog),
        .len_i   (bank_len),
        .word_i  (bank_word),
        .rd_addr (drain_addr),
        .done_o  (bank_done),
        .tx_data (tx_data),
        .tx_valid(tx_valid),
        .tx_ready(tx_ready),
        .tx_last (tx_last),
        .mac_addr(mac_addr)
    );

endmodule

// File: rtl/tx_pp_checker.sv
// Module: protocol checker bound to every tx_pingpong_ctrl instance.
// Does: checks stream hold, frame separation, interrupt shape, address
// stability during sends and quiet outputs after reset, all at the ports.
module tx_pp_checker #(
    parameter int BUF_BYTES = 2048,
    parameter int ADDR_W    = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [7:0]        tx_data,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              tx_last,
    input logic [47:0]       mac_addr,
    input logic              tx_irq
);

    localparam int OFF_W     = ADDR_W - 1;
    localparam int STAT_WIDX = (BUF_BYTES - 4) / 4;

    logic zero_stat_wr;
    assign zero_stat_wr = bus_en && bus_we && (bus_wdata == 32'd0) &&
                          (bus_addr[OFF_W-1:2] == (OFF_W-2)'(STAT_WIDX));

    // R1: reset leaves the stream and interrupt quiet.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!tx_valid && !tx_irq));

    // R4: a stalled byte holds until accepted (unless software resets).
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !zero_stat_wr) |=>
        (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R5: interrupt is a single-cycle pulse.
    a_r5_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    // R5: interrupt arrives after the frame, never while streaming.
    a_r5_irq_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> !tx_valid);

    // R9: one frame at a time, a gap follows every final byte.
    a_r9_frame_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid);

    // R6: the station address never changes while a frame streams.
    a_r6_mac_steady: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $stable(mac_addr));

endmodule

bind tx_pingpong_ctrl tx_pp_checker #(
    .BUF_BYTES(BUF_BYTES),
    .ADDR_W   (ADDR_W)
) u_chk (.*);

// File: tb/tb_tx_pingpong_ctrl.sv
// Bench: vector table of frames walked by one loop, then directed tests.
module tb_tx_pingpong_ctrl;

    localparam logic [11:0] PONG = 12'h800;
    localparam logic [11:0] LENO = 12'h7F4;
    localparam logic [11:0] STAO = 12'h7FC;
    // Vector: [31] pong, [24] irq enable, [23:16] seed, [15:0] length.
    localparam logic [31:0] VEC [0:5] = '{
        32'h0111_0001, 32'h8040_0004, 32'h01A3_0007,
        32'h8105_0040, 32'h00F0_000D, 32'h8177_0009
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, np_rdata;
    logic [7:0]  tx_data, np_data;
    logic        tx_valid, tx_last, np_valid, np_last, tx_irq, np_irq;
    logic [47:0] mac_addr, np_mac;
    logic        rdy_hold = 1'b0;
    logic        bp_mode = 1'b0;
    logic [7:0]  lfsr = 8'h5A;
    logic        tx_ready;

    int          n_cmp = 0;
    int          n_bad = 0;
    int          cap_n = 0;
    logic [7:0]  cap_data [0:4095];
    logic        cap_last [0:4095];
    int          irq_cnt = 0;
    int          hold_err = 0;
    int          np_cnt = 0;
    int          cyc = 0;
    logic        prev_stall = 1'b0;
    logic [7:0]  prev_data = '0;

    assign tx_ready = !rdy_hold && (!bp_mode || lfsr[0]);

    always #10 clk = ~clk;

    tx_pingpong_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_last(tx_last), .mac_addr(mac_addr), .tx_irq(tx_irq)
    );

    tx_pingpong_ctrl #(.HAS_PONG(1'b0)) dut_np (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(np_rdata),
        .tx_data(np_data), .tx_valid(np_valid), .tx_ready(1'b1),
        .tx_last(np_last), .mac_addr(np_mac), .tx_irq(np_irq)
    );

    // Back-pressure pattern generator.
    always @(posedge clk) begin
        #1 lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end

    // Stream, interrupt and hold monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall && (!tx_valid || tx_data != prev_data)) hold_err++;
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            if (tx_valid && tx_ready) begin
                cap_data[cap_n] = tx_data;
                cap_last[cap_n] = tx_last;
                cap_n++;
            end
            if (tx_irq) irq_cnt++;
            if (np_valid) np_cnt++;
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles exp fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h exp %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [7:0] s, input int k);
        return s + 8'(k * 7);
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d,
                      output logic [31:0] dn);
        @(posedge clk); #1;
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_en = 1'b0;
        d  = bus_rdata;
        dn = np_rdata;
    endtask

    task automatic fill(input logic [11:0] base, input logic [7:0] s, input int n);
        for (int w = 0; w < (n + 3) / 4; w++) begin
            wr(base + 12'(4 * w), {pat(s, 4*w), pat(s, 4*w+1), pat(s, 4*w+2), pat(s, 4*w+3)});
        end
    endtask

    task automatic wait_idle(input logic [11:0] base, output bit ok);
        logic [31:0] v, vn;
        ok = 1'b0;
        for (int i = 0; i < 8000; i++) begin
            rd(base + STAO, v, vn);
            if (!v[0]) begin
                ok = 1'b1;
                break;
            end
        end
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic chk_frame(input int start, input logic [7:0] s, input int n,
                             input string req);
        int bad;
        bad = 0;
        for (int k = 0; k < n; k++) begin
            if (cap_data[start+k] != pat(s, k)) bad++;
            if (cap_last[start+k] != (k == n - 1)) bad++;
        end
        chk(bad == 0, req, "frame bytes/last mismatches", 64'(bad), 64'd0);
    endtask

    initial begin
        logic [31:0] v, vn;
        bit ok;
        int i0;

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state.
        rd(STAO, v, vn);          chk(v == 0, "R1", "ping status", 64'(v), 0);
        rd(PONG + STAO, v, vn);   chk(v == 0, "R1", "pong status", 64'(v), 0);
        rd(LENO, v, vn);          chk(v == 0, "R1", "ping length", 64'(v), 0);
        chk(!tx_valid && !tx_irq && mac_addr == 0, "R1", "outputs",
            {tx_valid, tx_irq, mac_addr}, 0);

        // R3 R5: table of frames.
        for (int i = 0; i < 6; i++) begin
            logic [11:0] base;
            logic [7:0]  s;
            int          n, irq0;
            base    = VEC[i][31] ? PONG : 12'h000;
            s       = VEC[i][23:16];
            n       = int'(VEC[i][15:0]);
            bp_mode = i[0];
            fill(base, s, n);
            wr(base + LENO, 32'(n));
            cap_n = 0;
            irq0  = irq_cnt;
            wr(base + STAO, {28'd0, VEC[i][24], 3'b001});
            wait_idle(base, ok);
            chk(ok, "R5", "busy cleared", 64'(ok), 1);
            chk(cap_n == n, "R3", "byte count", 64'(cap_n), 64'(n));
            chk_frame(0, s, n, "R3");
            chk(irq_cnt - irq0 == int'(VEC[i][24]), "R5", "irq pulses",
                64'(irq_cnt - irq0), 64'(VEC[i][24]));
            rd(base + STAO, v, vn);
            chk(v == {28'd0, VEC[i][24], 3'b000}, "R5", "status after", 64'(v),
                64'({VEC[i][24], 3'b000}));
        end
        bp_mode = 1'b0;
        chk(hold_err == 0, "R4", "stalled byte changed", 64'(hold_err), 0);

        // R2: length and status field placement.
        wr(PONG + LENO, 32'hFFFF_0123);
        rd(PONG + LENO, v, vn);   chk(v == 32'h0000_0123, "R2", "length bits", 64'(v), 64'h123);
        wr(PONG + STAO, 32'hFFFF_FFF4);
        rd(PONG + STAO, v, vn);   chk(v == 32'h8000_0000, "R2", "status bits", 64'(v), 64'h8000_0000);

        // R7: software flag stored, no transfer.
        cap_n = 0;
        wr(STAO, 32'h8000_0008);
        repeat (20) @(posedge clk);
        #1;
        rd(STAO, v, vn);          chk(v == 32'h8000_0008, "R7", "flag readback", 64'(v), 64'h8000_0008);
        chk(cap_n == 0, "R7", "bytes sent by flag", 64'(cap_n), 0);
        wr(STAO, 32'h0);
        wr(PONG + STAO, 32'h0);

        // R6: program station address, with irq enable set.
        wr(12'h000, 32'h0A1B_2C3D);
        wr(12'h004, 32'h4E5F_6677);
        cap_n = 0;
        i0 = irq_cnt;
        wr(STAO, 32'h0000_000B);
        wait_idle(12'h000, ok);
        chk(mac_addr == 48'h0A1B_2C3D_4E5F, "R6", "mac", mac_addr, 48'h0A1B_2C3D_4E5F);
        rd(STAO, v, vn);          chk(v == 32'h8, "R6", "status after program", 64'(v), 8);
        chk(cap_n == 0 && irq_cnt == i0, "R6", "stream bytes + irqs",
            64'(cap_n + irq_cnt - i0), 0);

        // R9: both armed while stalled, pong first.
        fill(PONG, 8'h60, 5);  wr(PONG + LENO, 32'd5);
        fill(12'h000, 8'h90, 6); wr(LENO, 32'd6);
        rdy_hold = 1'b1;
        cap_n = 0;
        wr(PONG + STAO, 32'h1);
        wr(STAO, 32'h1);
        repeat (5) @(posedge clk);
        #1 rdy_hold = 1'b0;
        wait_idle(12'h000, ok);
        wait_idle(PONG, ok);
        chk(cap_n == 11, "R9", "total bytes", 64'(cap_n), 11);
        chk_frame(0, 8'h60, 5, "R9");
        chk_frame(5, 8'h90, 6, "R9");

        // R10: zero length.
        wr(LENO, 32'd0);
        cap_n = 0;
        i0 = irq_cnt;
        wr(STAO, 32'h9);
        wait_idle(12'h000, ok);
        chk(ok && cap_n == 0, "R10", "bytes for zero length", 64'(cap_n), 0);
        chk(irq_cnt - i0 == 1, "R10", "irq pulses", 64'(irq_cnt - i0), 1);

        // R11: oversize length clamped to 2036.
        fill(12'h000, 8'h21, 2036);
        wr(LENO, 32'd3000);
        cap_n = 0;
        wr(STAO, 32'h1);
        wait_idle(12'h000, ok);
        chk(cap_n == 2036, "R11", "clamped count", 64'(cap_n), 2036);
        chk_frame(0, 8'h21, 2036, "R11");

        // R8: nonzero write keeps busy, zero write aborts.
        fill(PONG, 8'h33, 100);
        wr(PONG + LENO, 32'd100);
        rdy_hold = 1'b1;
        cap_n = 0;
        i0 = irq_cnt;
        wr(PONG + STAO, 32'h9);
        repeat (10) @(posedge clk);
        #1;
        chk(tx_valid, "R8", "valid while stalled", 64'(tx_valid), 1);
        wr(PONG + STAO, 32'h8);
        rd(PONG + STAO, v, vn);   chk(v == 32'h9, "R8", "busy kept", 64'(v), 9);
        wr(PONG + STAO, 32'h0);
        chk(!tx_valid, "R8", "valid after zero write", 64'(tx_valid), 0);
        rdy_hold = 1'b0;
        repeat (20) @(posedge clk);
        #1;
        chk(cap_n == 0 && irq_cnt == i0, "R8", "bytes + irqs after abort",
            64'(cap_n + irq_cnt - i0), 0);
        rd(PONG + STAO, v, vn);   chk(v == 0, "R8", "status after abort", 64'(v), 0);

        // R12: second region absent in dut_np.
        np_cnt = 0;
        fill(PONG, 8'h44, 8);
        wr(PONG + LENO, 32'd8);
        wr(PONG + STAO, 32'h9);
        repeat (30) @(posedge clk);
        #1;
        chk(np_cnt == 0 && !np_irq, "R12", "absent pong sent bytes", 64'(np_cnt), 0);
        rd(PONG + STAO, v, vn);   chk(vn == 0, "R12", "absent pong status", 64'(vn), 0);
        rd(PONG + LENO, v, vn);   chk(vn == 0, "R12", "absent pong length", 64'(vn), 0);
        wait_idle(PONG, ok);

        summary();
        $finish;
    end

endmodule